// File: doc/BRIEF.md
# Dual-Read Split Data Memory

This block is a word-organised data memory that sits behind a byte address space. The space is cut into a lower X region and an upper Y region. The boundary is a build-time parameter and cannot change while the block runs. The X read port always sees the whole space as one linear map. The Y read port only serves addresses that fall inside the Y region. When the split view is selected, the two ports hand back two independent words in the same clock cycle. This is what a dual-operand multiply-accumulate step needs to fetch both of its operands at once.

The block has a single write port. It always decodes its address against the combined map, whichever view is selected. A write can store a whole word or one byte lane. Read data comes out of a register, so it appears one cycle after the address. Address generation, wrap-around and reversed-carry addressing, and instruction decode all belong to the surrounding datapath.

Top module: `dualread_split_mem`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `x_rdata`, `y_rdata` and `y_err` are all zero after that edge.
- R2: `x_rdata` shows the word at byte address `x_addr` one clock after the address is presented. This holds for any physically present address in the X or Y region, in either view.
- R3: Reads ignore address bit 0. An odd byte address returns the same word as the even address just below it.
- R4: With `split_mode`=1, an X-port read and a Y-port read whose address lies in the Y region both return their words in the same cycle, and `y_err` stays 0.
- R5: With `split_mode`=1, a `y_addr` below `Y_BASE` or at or above `Y_LIMIT` gives `y_rdata`=0 and `y_err`=1 one cycle later.
- R6: With `split_mode`=0, `y_rdata` is 0 and `y_err` is 0 one cycle later, whatever `y_addr` holds.
- R7: A word write (`wr_en`=1, `wr_byte`=0) stores `wr_data` into word `wr_addr[15:1]` through the combined map. It does so in both views, including into the Y region while `split_mode`=1.
- R8: A byte write (`wr_byte`=1) stores `wr_data[7:0]` into one lane and leaves the other lane unchanged. `wr_addr[0]`=0 selects bits 7:0 and `wr_addr[0]`=1 selects bits 15:8.
- R9: A read of a word index at or above `DEPTH_WORDS` returns 0 on either port, and a write there changes no stored word.
- R10: A read of the word being written in the same cycle returns the old contents. The new contents appear from the next read onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| split_mode | input | 1 | 0 = unified view, 1 = split view (Y port active) |
| x_addr | input | 16 | Byte address for the X read port |
| y_addr | input | 16 | Byte address for the Y read port |
| wr_en | input | 1 | Write strobe |
| wr_byte | input | 1 | 1 = single byte lane write, 0 = word write |
| wr_addr | input | 16 | Byte address for the write, combined map |
| wr_data | input | 16 | Write data; byte writes take bits 7:0 |
| x_rdata | output | 16 | Registered X-port read word |
| y_rdata | output | 16 | Registered Y-port read word |
| y_err | output | 1 | Registered flag for a Y-port address outside the Y region in split view |

## Verification
The two read ports can fetch from the Y bank in the same cycle that the write port updates a word there. The bench sets up this collision by pointing both read addresses at the word being written while `split_mode` is 1. It then expects both outputs to carry the old value at that edge and the new value on the following read. Full sweeps also read every X word alongside every Y word with mixed bit-0 values. Their expected values come from a bench-side array that is updated only by the write rules.

// File: rtl/dm_pkg.sv
// Shared definitions for the split data memory.
// Assumes a 16-bit word made of two byte lanes.
package dm_pkg;
    localparam int WORD_W = 16;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic {
        VIEW_UNIFIED = 1'b0,
        VIEW_SPLIT   = 1'b1
    } view_e;

    // Lane enables for a word write or a single byte write.
    function automatic logic [LANES-1:0] lane_mask(input logic is_byte, input logic hi);
        if (!is_byte) return '1;
        return hi ? 2'b10 : 2'b01;
    endfunction

    // A byte write repeats the low byte on both lanes; the mask picks one.
    function automatic logic [WORD_W-1:0] lane_data(input logic is_byte, input logic [WORD_W-1:0] d);
        return is_byte ? {d[7:0], d[7:0]} : d;
    endfunction
endpackage

// File: rtl/dm_decode.sv
// Address decoder for one port.
// Turns a byte address into a word index, a flag for physical presence,
// and a flag for whether the address lies below the X/Y boundary.
// Assumes Y_BASE is even and no larger than the physical byte size.
module dm_decode #(
    parameter int ADDR_W      = 16,
    parameter int DEPTH_WORDS = 512,
    parameter int Y_BASE      = 16'h0200
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-2:0] word,
    output logic              in_phys,
    output logic              below_base
);
    localparam int PHYS_BYTES = DEPTH_WORDS * 2;

    // Purely combinational split of the byte address.
    always_comb begin
        word       = addr[ADDR_W-1:1];
        in_phys    = int'(addr) < PHYS_BYTES;
        below_base = int'(addr) < Y_BASE;
    end
endmodule

// File: rtl/dm_bank.sv
// One storage bank with a byte-lane write port and NRD combinational read ports.
// Assumes the caller only raises `we` for an index below WORDS.
// Storage is not reset.
module dm_bank #(
    parameter int WORDS = 256,
    parameter int NRD   = 1,
    parameter int DW    = 16,
    localparam int LW   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int NL   = DW / 8
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [LW-1:0]          wr_idx,
    input  logic [NL-1:0]          wr_lanes,
    input  logic [DW-1:0]          wr_data,
    input  logic [NRD-1:0][LW-1:0] rd_idx,
    output logic [NRD-1:0][DW-1:0] rd_data
);
    logic [DW-1:0] mem [WORDS];

    // Lane-masked write of one word.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NL; b++) begin
                if (wr_lanes[b]) mem[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    // One asynchronous read mux per read port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = mem[rd_idx[g]];
    end
endmodule

// File: rtl/dualread_split_mem.sv
// Top of the split data memory.
// The X bank holds the words below Y_BASE and the Y bank holds the rest of
// the physical words. The X port reads either bank. The Y port reads only the
// Y bank, and only in split view. The write port uses the combined map.
// Read outputs are registered.
// Assumes 0 < Y_BASE < 2*DEPTH_WORDS, Y_BASE even, and Y_LIMIT > Y_BASE.
module dualread_split_mem #(
    parameter int ADDR_W      = 16,
    parameter int DEPTH_WORDS = 512,
    parameter int Y_BASE      = 16'h0200,
    parameter int Y_LIMIT     = 16'h8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        split_mode,
    input  logic [15:0] x_addr,
    input  logic [15:0] y_addr,
    input  logic        wr_en,
    input  logic        wr_byte,
    input  logic [15:0] wr_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] x_rdata,
    output logic [15:0] y_rdata,
    output logic        y_err
);
    import dm_pkg::*;

    localparam int XW  = Y_BASE / 2;
    localparam int YW  = DEPTH_WORDS - XW;
    localparam int LXW = (XW > 1) ? $clog2(XW) : 1;
    localparam int LYW = (YW > 1) ? $clog2(YW) : 1;
    localparam int PX = 0, PY = 1, PW = 2;

    logic [2:0][ADDR_W-1:0] port_addr;
    logic [2:0][ADDR_W-2:0] dword;
    logic [2:0][ADDR_W-2:0] yoff;
    logic [2:0]             dphys;
    logic [2:0]             dlow;

    assign port_addr[PX] = x_addr;
    assign port_addr[PY] = y_addr;
    assign port_addr[PW] = wr_addr;

    // One decoder per port, plus the word offset into the Y bank.
    for (genvar g = 0; g < 3; g++) begin : g_dec
        dm_decode #(
            .ADDR_W     (ADDR_W),
            .DEPTH_WORDS(DEPTH_WORDS),
            .Y_BASE     (Y_BASE)
        ) u_dec (
            .addr      (port_addr[g]),
            .word      (dword[g]),
            .in_phys   (dphys[g]),
            .below_base(dlow[g])
        );
        assign yoff[g] = dword[g] - (ADDR_W-1)'(XW);
    end

    // Write steering: each physical word lives in exactly one bank.
    logic            wr_x, wr_y;
    logic [LANES-1:0] wr_lanes;
    logic [WORD_W-1:0] wr_word;

    // Decide which bank takes the write and which lanes it touches.
    always_comb begin
        wr_x     = wr_en && dphys[PW] &&  dlow[PW];
        wr_y     = wr_en && dphys[PW] && !dlow[PW];
        wr_lanes = lane_mask(wr_byte, wr_addr[0]);
        wr_word  = lane_data(wr_byte, wr_data);
    end

    logic [0:0][LXW-1:0]    xb_idx;
    logic [0:0][WORD_W-1:0] xb_rd;
    logic [1:0][LYW-1:0]    yb_idx;
    logic [1:0][WORD_W-1:0] yb_rd;

    assign xb_idx[0] = dword[PX][LXW-1:0];
    assign yb_idx[0] = yoff[PX][LYW-1:0];
    assign yb_idx[1] = yoff[PY][LYW-1:0];

    dm_bank #(.WORDS(XW), .NRD(1), .DW(WORD_W)) u_xbank (
        .clk     (clk),
        .we      (wr_x),
        .wr_idx  (dword[PW][LXW-1:0]),
        .wr_lanes(wr_lanes),
        .wr_data (wr_word),
        .rd_idx  (xb_idx),
        .rd_data (xb_rd)
    );

    dm_bank #(.WORDS(YW), .NRD(2), .DW(WORD_W)) u_ybank (
        .clk     (clk),
        .we      (wr_y),
        .wr_idx  (yoff[PW][LYW-1:0]),
        .wr_lanes(wr_lanes),
        .wr_data (wr_word),
        .rd_idx  (yb_idx),
        .rd_data (yb_rd)
    );

    view_e       view;
    logic        y_in_region;
    logic [15:0] x_next, y_next;
    logic        err_next;

    // Select and zero-fill the next values of the read registers.
    always_comb begin
        view        = view_e'(split_mode);
        y_in_region = !dlow[PY] && (int'(y_addr) < Y_LIMIT);
        x_next      = '0;
        if (dphys[PX]) x_next = dlow[PX] ? xb_rd[0] : yb_rd[0];
        y_next   = '0;
        err_next = 1'b0;
        if (view == VIEW_SPLIT) begin
            if (!y_in_region)   err_next = 1'b1;
            else if (dphys[PY]) y_next   = yb_rd[1];
        end
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_rdata <= '0;
            y_rdata <= '0;
            y_err   <= 1'b0;
        end else begin
            x_rdata <= x_next;
            y_rdata <= y_next;
            y_err   <= err_next;
        end
    end
endmodule

// File: rtl/dm_checker.sv
// Port-level temporal properties of dualread_split_mem, attached with bind.
module dm_checker #(
    parameter int ADDR_W      = 16,
    parameter int DEPTH_WORDS = 512,
    parameter int Y_BASE      = 16'h0200,
    parameter int Y_LIMIT     = 16'h8000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        split_mode,
    input logic [15:0] x_addr,
    input logic [15:0] y_addr,
    input logic [15:0] x_rdata,
    input logic [15:0] y_rdata,
    input logic        y_err
);
    localparam int PHYS_BYTES = DEPTH_WORDS * 2;

    p_unified_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !split_mode |=> (y_rdata == 16'h0 && !y_err));

    p_err_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        y_err |-> y_rdata == 16'h0);

    p_outside_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (split_mode && (int'(y_addr) < Y_BASE || int'(y_addr) >= Y_LIMIT)) |=> y_err);

    p_inside_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (split_mode && int'(y_addr) >= Y_BASE && int'(y_addr) < Y_LIMIT) |=> !y_err);

    p_x_absent_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(x_addr) >= PHYS_BYTES) |=> x_rdata == 16'h0);

    p_y_absent_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (split_mode && int'(y_addr) >= PHYS_BYTES) |=> y_rdata == 16'h0);
endmodule

bind dualread_split_mem dm_checker #(
    .ADDR_W     (ADDR_W),
    .DEPTH_WORDS(DEPTH_WORDS),
    .Y_BASE     (Y_BASE),
    .Y_LIMIT    (Y_LIMIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .split_mode(split_mode),
    .x_addr    (x_addr),
    .y_addr    (y_addr),
    .x_rdata   (x_rdata),
    .y_rdata   (y_rdata),
    .y_err     (y_err)
);

// File: tb/sim_dualread_split_mem.sv
`timescale 1ns/100ps
module sim_dualread_split_mem;
    localparam int DEPTH   = 512;
    localparam int YBASE   = 16'h0200;
    localparam int YLIMIT  = 16'h8000;
    localparam int XW      = YBASE / 2;
    localparam int YW      = DEPTH - XW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        split_mode = 1'b0;
    logic [15:0] x_addr = '0, y_addr = '0, wr_addr = '0, wr_data = '0;
    logic        wr_en = 1'b0, wr_byte = 1'b0;
    logic [15:0] x_rdata, y_rdata;
    logic        y_err;

    int checks = 0;
    int failures = 0;
    logic [15:0] model [DEPTH];

    always #2.5 clk = ~clk;

    dualread_split_mem #(
        .DEPTH_WORDS(DEPTH), .Y_BASE(YBASE), .Y_LIMIT(YLIMIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode),
        .x_addr(x_addr), .y_addr(y_addr),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_addr(wr_addr), .wr_data(wr_data),
        .x_rdata(x_rdata), .y_rdata(y_rdata), .y_err(y_err)
    );

    function automatic logic [15:0] pat(input int i);
        return 16'((i * 40503) ^ 16'h5A5A);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write per R7/R8/R9; the bench array follows the same rules.
    task automatic wr(input logic md, input logic [15:0] a, input logic [15:0] d, input logic byt);
        @(negedge clk);
        split_mode = md; wr_en = 1'b1; wr_addr = a; wr_data = d; wr_byte = byt;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (int'(a) < DEPTH * 2) begin
            if (!byt) model[a[15:1]] = d;
            else if (a[0]) model[a[15:1]][15:8] = d[7:0];
            else model[a[15:1]][7:0] = d[7:0];
        end
    endtask

    task automatic rd(input logic md, input logic [15:0] xa, input logic [15:0] ya);
        @(negedge clk);
        split_mode = md; x_addr = xa; y_addr = ya; wr_en = 1'b0;
        @(posedge clk); #1;
    endtask

    function automatic logic [15:0] ex_x(input logic [15:0] a);
        return (int'(a) < DEPTH * 2) ? model[a[15:1]] : 16'h0;
    endfunction

    function automatic logic ex_err(input logic md, input logic [15:0] a);
        return md && (int'(a) < YBASE || int'(a) >= YLIMIT);
    endfunction

    function automatic logic [15:0] ex_y(input logic md, input logic [15:0] a);
        if (!md || ex_err(md, a) || int'(a) >= DEPTH * 2) return 16'h0;
        return model[a[15:1]];
    endfunction

    task automatic rd_chk(input string req, input logic md, input logic [15:0] xa, input logic [15:0] ya);
        rd(md, xa, ya);
        check({req, " x"}, x_rdata, ex_x(xa));
        check({req, " y"}, y_rdata, ex_y(md, ya));
        check({req, " err"}, {15'h0, y_err}, {15'h0, ex_err(md, ya)});
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [15:0] oldv, newv;
        x_addr = 16'h0010; y_addr = 16'h0000; split_mode = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs cleared while reset is held
        check("R1 x", x_rdata, 16'h0);
        check("R1 y", y_rdata, 16'h0);
        check("R1 err", {15'h0, y_err}, 16'h0);
        @(negedge clk); rst_n = 1'b1;

        // R7: X words written in unified view, Y words in split view
        for (int w = 0; w < DEPTH; w++) wr(w >= XW, 16'(2 * w), pat(w), 1'b0);

        // R2/R6: unified sweep over every word, Y port must stay quiet
        for (int w = 0; w < DEPTH; w++) rd_chk("R2 R6 unified", 1'b0, 16'(2 * w), 16'(YBASE + 2 * (w % YW)));

        // R4/R3: concurrent X and Y reads, odd addresses on alternate words
        for (int i = 0; i < XW; i++)
            rd_chk("R4 R3 split", 1'b1, 16'(2 * i + 1), 16'(YBASE + 2 * (i % YW) + (i % 2)));

        // R5: Y addresses just outside the Y region
        rd_chk("R5 below", 1'b1, 16'h0002, 16'(YBASE - 2));
        rd_chk("R5 below odd", 1'b1, 16'h0004, 16'(YBASE - 1));
        rd_chk("R5 zero", 1'b1, 16'h0006, 16'h0000);
        rd_chk("R5 limit", 1'b1, 16'h0008, 16'(YLIMIT));
        rd_chk("R5 top", 1'b1, 16'h000A, 16'hFFFE);
        rd_chk("R4 base", 1'b1, 16'h000C, 16'(YBASE));
        // R9: reads beyond the physical words
        rd_chk("R9 y absent", 1'b1, 16'(DEPTH * 2), 16'(YLIMIT - 2));
        rd_chk("R9 x top", 1'b1, 16'hFFFE, 16'(DEPTH * 2 - 1));

        // R8: byte writes on both lanes in both regions
        for (int k = 0; k < 16; k++) begin
            wr(k[0], 16'(2 * (k * 37 % DEPTH) + (k % 2)), 16'(16'h3C00 | (k * 29)), 1'b1);
            rd_chk("R8 byte lane", 1'b1, 16'(2 * (k * 37 % DEPTH)), 16'(YBASE + 2 * (k % YW)));
        end
        wr(1'b1, 16'(YBASE + 7), 16'hFFA5, 1'b1);
        rd_chk("R8 hi lane", 1'b1, 16'(YBASE + 6), 16'(YBASE + 6));

        // R9: writes beyond the physical words must not alias
        wr(1'b0, 16'(DEPTH * 2), 16'hDEAD, 1'b0);
        wr(1'b0, 16'hFFFE, 16'hBEEF, 1'b0);
        rd_chk("R9 no alias low", 1'b1, 16'h0000, 16'(YBASE));
        rd_chk("R9 no alias high", 1'b1, 16'(DEPTH * 2 - 2), 16'(DEPTH * 2 - 2));

        // R10: both ports read the word being written in the same cycle
        oldv = model[XW + 7];
        newv = ~oldv;
        @(negedge clk);
        split_mode = 1'b1; x_addr = 16'(YBASE + 14); y_addr = 16'(YBASE + 15);
        wr_en = 1'b1; wr_byte = 1'b0; wr_addr = 16'(YBASE + 14); wr_data = newv;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model[XW + 7] = newv;
        check("R10 x old", x_rdata, oldv);
        check("R10 y old", y_rdata, oldv);
        rd_chk("R10 new", 1'b1, 16'(YBASE + 14), 16'(YBASE + 14));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule